// File: doc/BRIEF.md
# Triggered Pulse Train and Delayed Gate Generator

Each rising edge of an external trigger starts a finite timing burst. During a window of programmable length, one output gives a single-cycle marker at a fixed programmable spacing. A scaler uses this marker to advance to its next time bin. A second output gives a narrow enable window for each marker. The window opens a programmable number of cycles after the marker and stays open for a programmable number of cycles. This output drives the scaler's counting gate. The same repetitive signal can be acquired several times, with the gate offset stepped by one cycle on each run. This gives time resolution much finer than the marker spacing. All settings are counted in clock cycles.

The trigger passes through a synchroniser and an edge detector. A state machine with three states runs the burst:
- `ST_IDLE` waits for a trigger edge. On the edge, the transition *start* captures the settings and enters `ST_RUN`.
- `ST_RUN` steps a phase counter and a window counter. The transition *window_end* moves to `ST_DONE` on the last window cycle.
- `ST_DONE` raises the finish strobe for one cycle. The transition *retire* then returns to `ST_IDLE`.

A trigger edge seen in `ST_RUN` or `ST_DONE` does not restart the burst. Instead it raises a sticky overlap flag.

Top module: `burst_gate_gen`

## Requirements
- R1: The trigger is sampled on rising clock edges. The first marker of a burst appears in the clock cycle that follows the third rising edge at which the trigger is sampled high. `busy` is still low in the cycle before that.
- R2: With effective period P and effective window L, `bin_pulse` is high for exactly one cycle at window offsets 0, P, 2P, and so on, for every offset below L. It is low at all other times.
- R3: With effective delay D and width W, `gate_out` is high at each window offset t where (t mod P) lies in the range D to D+W-1. It is high only inside the window. It is never high while idle.
- R4: If D plus the requested width is greater than or equal to P, the width is reduced to P-1-D, or to 0 when D is P-1 or more. Each gate therefore ends at least one cycle before the next marker.
- R5: A period setting below 2 is treated as 2. A window setting of 0 is treated as 1, which gives a single marker.
- R6: `burst_done` is high for one cycle, in the cycle directly after the last window cycle. `busy` is high from the first window cycle through that done cycle, and low in the cycle after it.
- R7: A trigger rising edge while `busy` is high does not change the running burst. It sets `overlap_flag`, which stays high until reset.
- R8: A trigger held high starts only one burst. No further burst starts until the trigger has gone low and risen again.
- R9: The settings are captured when a burst starts. Changing them during a burst does not change that burst's marker spacing.
- R10: While reset is asserted, `bin_pulse`, `gate_out`, `burst_done`, `busy` and `overlap_flag` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Asynchronous external trigger |
| cfg_period | input | CNT_W | Marker spacing in cycles |
| cfg_window | input | CNT_W | Burst window length in cycles |
| cfg_delay | input | CNT_W | Gate offset after each marker, in cycles |
| cfg_width | input | CNT_W | Gate length in cycles |
| bin_pulse | output | 1 | Single-cycle bin-advance marker |
| gate_out | output | 1 | Counting-gate enable |
| burst_done | output | 1 | One-cycle strobe at the end of a burst |
| busy | output | 1 | High while a burst is running or finishing |
| overlap_flag | output | 1 | Sticky flag for a trigger edge that arrived while busy |

## Verification
The bench builds the block with `CNT_W` = 8 and `SYNC_STAGES` = 2. The narrow counters let a gate offset of 200 plus a width of 100 exceed the counter range. This exercises the one-bit-wider sum that the width clamp relies on. With two sync stages the trigger-to-marker latency is a short, fixed count. Small periods and windows then let every cycle of a burst be compared, including the clamped cases with period 0 and 1 and window 0.

// File: rtl/burst_gate_pkg.sv
package burst_gate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } burst_state_e;
endpackage

// File: rtl/burst_trig_sync.sv
module burst_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_out
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            last_q <= chain_q[SYNC_STAGES-1];
        end
    end

    assign rise_out = chain_q[SYNC_STAGES-1] & ~last_q;

    // An edge is reported for one cycle only (supports R8)
    assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_out |=> !rise_out);
endmodule

// File: rtl/burst_cfg.sv
module burst_cfg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_window,
    input  logic [CNT_W-1:0] cfg_delay,
    input  logic [CNT_W-1:0] cfg_width,
    output logic [CNT_W-1:0] per_q,
    output logic [CNT_W-1:0] win_q,
    output logic [CNT_W-1:0] dly_q,
    output logic [CNT_W-1:0] wid_q
);
    localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);

    logic [CNT_W-1:0] per_e, win_e, wid_e;
    logic [CNT_W:0]   span;

    always_comb begin
        per_e = (cfg_period < MIN_PER) ? MIN_PER : cfg_period;
        win_e = (cfg_window == '0) ? CNT_W'(1) : cfg_window;
        span  = {1'b0, cfg_delay} + {1'b0, cfg_width};
        if (span >= {1'b0, per_e}) begin
            wid_e = (cfg_delay < per_e - 1'b1) ? (per_e - 1'b1 - cfg_delay) : '0;
        end else begin
            wid_e = cfg_width;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= MIN_PER;
            win_q <= CNT_W'(1);
            dly_q <= '0;
            wid_q <= '0;
        end else if (load) begin
            per_q <= per_e;
            win_q <= win_e;
            dly_q <= cfg_delay;
            wid_q <= wid_e;
        end
    end

    assert_period_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q >= MIN_PER) && (win_q != '0));
    assert_gate_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wid_q == '0) || (({1'b0, dly_q} + {1'b0, wid_q}) < {1'b0, per_q}));
endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_gate_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_rise,
    input  logic [CNT_W-1:0] per_q,
    input  logic [CNT_W-1:0] win_q,
    input  logic [CNT_W-1:0] dly_q,
    input  logic [CNT_W-1:0] wid_q,
    output logic             load,
    output logic             bin_pulse,
    output logic             gate_out,
    output logic             burst_done,
    output logic             busy,
    output logic             overlap_flag
);
    burst_state_e     state_q;
    logic [CNT_W-1:0] ph_q;
    logic [CNT_W-1:0] cyc_q;

    assign load = (state_q == ST_IDLE) && trig_rise;

    // State register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            ph_q         <= '0;
            cyc_q        <= '0;
            overlap_flag <= 1'b0;
        end else begin
            if (trig_rise && (state_q != ST_IDLE)) begin
                overlap_flag <= 1'b1;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (trig_rise) begin
                        state_q <= ST_RUN;
                        ph_q    <= '0;
                        cyc_q   <= '0;
                    end
                end
                ST_RUN: begin
                    cyc_q <= cyc_q + 1'b1;
                    ph_q  <= (ph_q == per_q - 1'b1) ? '0 : ph_q + 1'b1;
                    if (cyc_q == win_q - 1'b1) begin
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        bin_pulse  = 1'b0;
        gate_out   = 1'b0;
        burst_done = 1'b0;
        busy       = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                bin_pulse = (ph_q == '0);
                gate_out  = (ph_q >= dly_q) &&
                            ({1'b0, ph_q} < ({1'b0, dly_q} + {1'b0, wid_q}));
            end
            ST_DONE: burst_done = 1'b1;
            default: ;
        endcase
    end

    assert_bin_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bin_pulse |=> !bin_pulse);
    assert_gate_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bin_pulse |-> !$past(gate_out));
    assert_quiet_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bin_pulse && !gate_out));
    assert_done_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> (!burst_done && !busy));
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_flag |=> overlap_flag);
endmodule

// File: rtl/burst_gate_gen.sv
module burst_gate_gen #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_window,
    input  logic [CNT_W-1:0] cfg_delay,
    input  logic [CNT_W-1:0] cfg_width,
    output logic             bin_pulse,
    output logic             gate_out,
    output logic             burst_done,
    output logic             busy,
    output logic             overlap_flag
);
    logic             trig_rise, load;
    logic [CNT_W-1:0] per_q, win_q, dly_q, wid_q;

    burst_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trig_in),
        .rise_out (trig_rise)
    );

    burst_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .cfg_period (cfg_period),
        .cfg_window (cfg_window),
        .cfg_delay  (cfg_delay),
        .cfg_width  (cfg_width),
        .per_q      (per_q),
        .win_q      (win_q),
        .dly_q      (dly_q),
        .wid_q      (wid_q)
    );

    burst_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_rise    (trig_rise),
        .per_q        (per_q),
        .win_q        (win_q),
        .dly_q        (dly_q),
        .wid_q        (wid_q),
        .load         (load),
        .bin_pulse    (bin_pulse),
        .gate_out     (gate_out),
        .burst_done   (burst_done),
        .busy         (busy),
        .overlap_flag (overlap_flag)
    );
endmodule

// File: tb/burst_gate_gen_bench.sv
module burst_gate_gen_bench;
    localparam int CW = 8;
    localparam int NV = 7;
    // {period, window, delay, width}
    localparam logic [31:0] VEC [NV] = '{
        {8'd5,  8'd12, 8'd1,   8'd2},
        {8'd4,  8'd8,  8'd0,   8'd1},
        {8'd6,  8'd10, 8'd3,   8'd5},
        {8'd1,  8'd5,  8'd0,   8'd1},
        {8'd0,  8'd0,  8'd0,   8'd0},
        {8'd10, 8'd25, 8'd200, 8'd100},
        {8'd3,  8'd7,  8'd2,   8'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_in = 1'b0;
    logic [CW-1:0] cfg_period = '0, cfg_window = '0, cfg_delay = '0, cfg_width = '0;
    logic bin_pulse, gate_out, burst_done, busy, overlap_flag;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    burst_gate_gen #(.CNT_W(CW), .SYNC_STAGES(2)) u_burst_gate_gen (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
        .cfg_period(cfg_period), .cfg_window(cfg_window),
        .cfg_delay(cfg_delay), .cfg_width(cfg_width),
        .bin_pulse(bin_pulse), .gate_out(gate_out), .burst_done(burst_done),
        .busy(busy), .overlap_flag(overlap_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic run_burst(input int p, input int l, input int d, input int w);
        int pe, le, we;
        string rb, rg;
        pe = (p < 2) ? 2 : p;
        le = (l == 0) ? 1 : l;
        if (d + w >= pe) we = (d < pe - 1) ? pe - 1 - d : 0;
        else we = w;
        rb = (p < 2 || l == 0) ? "R5" : "R2";
        rg = (d + w >= pe) ? "R4" : "R3";
        @(negedge clk);
        cfg_period = CW'(p); cfg_window = CW'(l);
        cfg_delay = CW'(d);  cfg_width = CW'(w);
        trig_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "busy before start", int'(busy), 0);
        @(negedge clk);
        for (int t = 0; t < le; t++) begin
            chk(rb, "bin_pulse", int'(bin_pulse), int'((t % pe) == 0));
            chk(rg, "gate_out", int'(gate_out),
                int'(((t % pe) >= d) && ((t % pe) < d + we)));
            chk("R6", "busy in window", int'(busy), 1);
            @(negedge clk);
        end
        chk("R6", "done strobe", int'(burst_done), 1);
        chk("R6", "busy at done", int'(busy), 1);
        @(negedge clk);
        chk("R6", "done cleared", int'(burst_done), 0);
        chk("R6", "busy cleared", int'(busy), 0);
        trig_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "bin_pulse", int'(bin_pulse), 0);
        chk("R10", "gate_out", int'(gate_out), 0);
        chk("R10", "burst_done", int'(burst_done), 0);
        chk("R10", "busy", int'(busy), 0);
        chk("R10", "overlap_flag", int'(overlap_flag), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_burst(int'(VEC[v][31:24]), int'(VEC[v][23:16]),
                      int'(VEC[v][15:8]),  int'(VEC[v][7:0]));
        end
        chk("R7", "flag clear after clean bursts", int'(overlap_flag), 0);

        // R7, R9: retrigger and settings change during a burst
        cfg_period = 8'd4; cfg_window = 8'd20; cfg_delay = 8'd1; cfg_width = 8'd1;
        trig_in = 1'b1;
        repeat (3) @(negedge clk);
        for (int t = 0; t < 20; t++) begin
            if (t == 2) trig_in = 1'b0;
            if (t == 3) cfg_period = 8'd7;
            if (t == 6) trig_in = 1'b1;
            chk("R9", "bin_pulse spacing kept", int'(bin_pulse), int'((t % 4) == 0));
            if (t == 15) chk("R7", "overlap flag set", int'(overlap_flag), 1);
            @(negedge clk);
        end
        chk("R7", "burst ends on schedule", int'(burst_done), 1);
        @(negedge clk);
        // R8: trigger still held high, no new burst
        for (int t = 0; t < 10; t++) begin
            chk("R8", "no restart on level", int'(busy | bin_pulse), 0);
            @(negedge clk);
        end
        chk("R7", "flag stays set", int'(overlap_flag), 1);

        // R10: reset clears the sticky flag
        rst_n = 1'b0;
        trig_in = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10", "flag cleared by reset", int'(overlap_flag), 0);
        chk("R10", "busy in reset", int'(busy), 0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule